// File: doc/BRIEF.md
# Level-Latched GPIO Register Block

This block is a 32-bit register slice that looks after twelve general-purpose I/O lines. Software selects, one line at a time, whether the line drives a value or is only sampled. Every line can also watch its synchronized input for a chosen level, either high or low. When that level is seen, a per-line status flag is set and held. A single host interrupt is raised while any flag that software has enabled is set.

Each status flag stays set after its source goes away and is acknowledged by writing a 1 to it. A flag whose source is still at the active level when it is acknowledged reads 0 for exactly one cycle and is then set again. For that reason software must remove the cause before it acknowledges. The block also holds a 32-bit pin-routing word, which it presents unchanged on an output port for a mux outside the block.

The bus side is a plain synchronous port. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from the address.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset every register reads zero: all lines are inputs, `pin_out` and `pin_oe` are zero, all lines are active-high, interrupts are masked, status is clear, `mux_sel` is zero and `host_irq` is low.
- R2: The drive-value register (offset 0x00, bit n = line n) appears on `pin_out`, and the drive-enable register (offset 0x04, bit n = line n, 1 = drive) appears on `pin_oe`. Both read back what was written.
- R3: The sample register (offset 0x08, bit n = line n) returns `pin_in` through a two-flop synchronizer. A change becomes visible after the second rising edge, and writes to this register have no effect.
- R4: The polarity of line n is bit 4·(n mod 8) of the register at offset 0x10 for n < 8, and of the register at offset 0x18 for n ≥ 8. A value of 0 means active-high and 1 means active-low. All other bits of these two registers read zero.
- R5: The status register (offset 0x0C, bit n = line n) sets a bit one edge after the synchronized line is at its active level. The bit stays set after the line returns to inactive.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: A status bit that is cleared while its line is still active reads 0 for one cycle and is set again on the following edge.
- R8: `host_irq` is high exactly when some line has both its status bit and its enable bit (offset 0x14, bit n = line n) set. Clearing an enable bit masks the line but keeps its status.
- R9: The routing register (offset 0x1C) stores all 32 bits, reads them back and drives them on `mux_sel`.
- R10: Register bits above bit 11, unaligned offsets and offsets from 0x20 upward read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| pin_in | input | NLINES (12) | Asynchronous line inputs |
| pin_out | output | NLINES (12) | Value each line drives |
| pin_oe | output | NLINES (12) | Per-line drive enable, 1 = drive |
| mux_sel | output | DATA_W (32) | Pin-routing control word |
| host_irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the following corner cases:
- Synchronizer depth: it reads the sample register after one edge and again after two. A design with the wrong number of stages shows the new value too early or too late.
- Acknowledge while the source is still active: it looks at the status bit in the cycle just after the clear and in the cycle after that. A design that ORs the live level into the cleared value never shows the zero. A design that does not re-latch never shows the bit coming back.
- Polarity field layout: it writes all ones to both polarity registers and checks which bits read back. It then drives one line active-low from the upper register. A wrong stride or register split shows up as bad readback or as a wrong line latching.
- Masking and ignored writes: it toggles enable bits with a latched flag present and writes to unaligned and out-of-range offsets. A design that drops status on a mask, or decodes too few address bits, changes the output ports.

// File: rtl/gpio_lvl_pkg.sv
`timescale 1ns/1ps
package gpio_lvl_pkg;

    localparam logic [15:0] OFS_DOUT   = 16'h0000;
    localparam logic [15:0] OFS_OE     = 16'h0004;
    localparam logic [15:0] OFS_SAMPLE = 16'h0008;
    localparam logic [15:0] OFS_STAT   = 16'h000C;
    localparam logic [15:0] OFS_POL_LO = 16'h0010;
    localparam logic [15:0] OFS_IEN    = 16'h0014;
    localparam logic [15:0] OFS_POL_HI = 16'h0018;
    localparam logic [15:0] OFS_ROUTE  = 16'h001C;

    // lines per polarity register, and bit stride between their fields
    localparam int unsigned POL_PER_REG = 8;
    localparam int unsigned POL_STRIDE  = 4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DOUT,
        SEL_OE,
        SEL_SAMPLE,
        SEL_STAT,
        SEL_POL_LO,
        SEL_IEN,
        SEL_POL_HI,
        SEL_ROUTE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [15:0] a);
        reg_sel_e s;
        case (a)
            OFS_DOUT:   s = SEL_DOUT;
            OFS_OE:     s = SEL_OE;
            OFS_SAMPLE: s = SEL_SAMPLE;
            OFS_STAT:   s = SEL_STAT;
            OFS_POL_LO: s = SEL_POL_LO;
            OFS_IEN:    s = SEL_IEN;
            OFS_POL_HI: s = SEL_POL_HI;
            OFS_ROUTE:  s = SEL_ROUTE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] settled;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta    = async_in;
        sync_d.settled = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.settled;

endmodule

// File: rtl/gpio_lvl_latch.sv
`timescale 1ns/1ps
module gpio_lvl_latch #(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] ack,
    output logic [N-1:0] active,
    output logic [N-1:0] status
);

    logic [N-1:0] stat_d, stat_q;

    // polarity 1 inverts the sampled level (active-low)
    assign active = level_in ^ pol;

    // an acknowledged bit drops for this edge; a still-active source re-sets it next edge
    always_comb begin
        stat_d = (stat_q | active) & ~ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;

endmodule

// File: rtl/gpio_ctl_regs.sv
`timescale 1ns/1ps
module gpio_ctl_regs
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned N  = 12,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  sample,
    input  logic [N-1:0]  status,
    output logic [N-1:0]  dout,
    output logic [N-1:0]  oe,
    output logic [N-1:0]  ien,
    output logic [N-1:0]  pol,
    output logic [DW-1:0] route,
    output logic [N-1:0]  ack,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [N-1:0]  dout;
        logic [N-1:0]  oe;
        logic [N-1:0]  ien;
        logic [N-1:0]  pol;
        logic [DW-1:0] route;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            case (sel)
                SEL_DOUT:  ctl_d.dout  = wdata[N-1:0];
                SEL_OE:    ctl_d.oe    = wdata[N-1:0];
                SEL_IEN:   ctl_d.ien   = wdata[N-1:0];
                SEL_ROUTE: ctl_d.route = wdata;
                SEL_POL_LO: begin
                    for (int n = 0; n < N; n++) begin
                        if (n < POL_PER_REG)
                            ctl_d.pol[n] = wdata[POL_STRIDE*(n % POL_PER_REG)];
                    end
                end
                SEL_POL_HI: begin
                    for (int n = 0; n < N; n++) begin
                        if (n >= POL_PER_REG)
                            ctl_d.pol[n] = wdata[POL_STRIDE*(n % POL_PER_REG)];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ack = (we && sel == SEL_STAT) ? wdata[N-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DOUT:   rdata[N-1:0] = ctl_q.dout;
            SEL_OE:     rdata[N-1:0] = ctl_q.oe;
            SEL_SAMPLE: rdata[N-1:0] = sample;
            SEL_STAT:   rdata[N-1:0] = status;
            SEL_IEN:    rdata[N-1:0] = ctl_q.ien;
            SEL_ROUTE:  rdata        = ctl_q.route;
            SEL_POL_LO: begin
                for (int n = 0; n < N; n++) begin
                    if (n < POL_PER_REG)
                        rdata[POL_STRIDE*(n % POL_PER_REG)] = ctl_q.pol[n];
                end
            end
            SEL_POL_HI: begin
                for (int n = 0; n < N; n++) begin
                    if (n >= POL_PER_REG)
                        rdata[POL_STRIDE*(n % POL_PER_REG)] = ctl_q.pol[n];
                end
            end
            default: ;
        endcase
    end

    assign dout  = ctl_q.dout;
    assign oe    = ctl_q.oe;
    assign ien   = ctl_q.ien;
    assign pol   = ctl_q.pol;
    assign route = ctl_q.route;

endmodule

// File: rtl/gpio_lvl_irq.sv
`timescale 1ns/1ps
module gpio_lvl_irq
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned NLINES = 12,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic [DATA_W-1:0] mux_sel,
    output logic              host_irq
);

    logic [15:0]       addr_ext;
    reg_sel_e          sel;
    logic [NLINES-1:0] in_sync;
    logic [NLINES-1:0] pol_vec;
    logic [NLINES-1:0] ack_vec;
    logic [NLINES-1:0] act_vec;
    logic [NLINES-1:0] st_vec;
    logic [NLINES-1:0] en_vec;

    assign addr_ext = 16'(bus_addr);
    assign sel      = decode_addr(addr_ext);

    gpio_sync2 #(.W(NLINES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_lvl_latch #(.N(NLINES)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (in_sync),
        .pol      (pol_vec),
        .ack      (ack_vec),
        .active   (act_vec),
        .status   (st_vec)
    );

    gpio_ctl_regs #(.N(NLINES), .DW(DATA_W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .sel    (sel),
        .wdata  (bus_wdata),
        .sample (in_sync),
        .status (st_vec),
        .dout   (pin_out),
        .oe     (pin_oe),
        .ien    (en_vec),
        .pol    (pol_vec),
        .route  (mux_sel),
        .ack    (ack_vec),
        .rdata  (bus_rdata)
    );

    assign host_irq = |(st_vec & en_vec);

endmodule

// File: rtl/gpio_lvl_irq_chk.sv
`timescale 1ns/1ps
module gpio_lvl_irq_chk #(
    parameter int unsigned N      = 12,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic [DATA_W-1:0] mux_sel,
    input logic              host_irq,
    input logic [N-1:0]      st_vec,
    input logic [N-1:0]      en_vec,
    input logic [N-1:0]      act_vec
);

    logic          stat_wr;
    logic [N-1:0]  wr_ones;
    logic [N-1:0]  want_set;

    assign stat_wr  = bus_we && (bus_addr == ADDR_W'(gpio_lvl_pkg::OFS_STAT));
    assign wr_ones  = stat_wr ? bus_wdata[N-1:0] : '0;
    assign want_set = act_vec & ~wr_ones;

    // R6
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((st_vec & $past(bus_wdata[N-1:0])) == '0));

    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((st_vec & $past(st_vec)) == $past(st_vec)));

    // R7
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want_set != '0) |=> ((st_vec & $past(want_set)) == $past(want_set)));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_vec & en_vec) == '0) |-> !host_irq);

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe) && $stable(mux_sel)));

    // R10
    sample_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(gpio_lvl_pkg::OFS_SAMPLE)) |-> ((bus_rdata >> N) == '0));

endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.N(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mux_sel   (mux_sel),
    .host_irq  (host_irq),
    .st_vec    (st_vec),
    .en_vec    (en_vec),
    .act_vec   (act_vec)
);

// File: tb/gpio_lvl_irq_tb.sv
`timescale 1ns/1ps
module gpio_lvl_irq_tb_top;

    localparam logic [5:0] A_DOUT = 6'h00, A_OE = 6'h04, A_SAMP = 6'h08, A_STAT = 6'h0C;
    localparam logic [5:0] A_PLO = 6'h10, A_IEN = 6'h14, A_PHI = 6'h18, A_ROUTE = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out, pin_oe;
    logic [31:0] mux_sel;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_lvl_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .mux_sel(mux_sel), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [5:0] addrs [8] = '{A_DOUT, A_OE, A_SAMP, A_STAT, A_PLO, A_IEN, A_PHI, A_ROUTE};
        foreach (addrs[i]) begin
            rd(addrs[i], v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 pin_out", {20'h0, pin_out}, 32'h0);
        chk("R1 pin_oe", {20'h0, pin_oe}, 32'h0);
        chk("R1 mux_sel", mux_sel, 32'h0);
        chk("R1 host_irq", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_drive();
        logic [31:0] v;
        wr(A_DOUT, 32'hFFFF_F5A5);
        rd(A_DOUT, v);
        chk("R2 dout readback", v, 32'h5A5);
        chk("R2 pin_out", {20'h0, pin_out}, 32'h5A5);
        wr(A_OE, 32'h0000_00F0);
        rd(A_OE, v);
        chk("R2 oe readback", v, 32'h0F0);
        chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0F0);
        chk("R2 pin_out kept", {20'h0, pin_out}, 32'h5A5);
    endtask

    task automatic t_sample();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 12'hA5C;
        cyc(1);
        rd(A_SAMP, v);
        chk("R3 sample after one edge", v, 32'h0);
        cyc(1);
        rd(A_SAMP, v);
        chk("R3 sample after two edges", v, 32'hA5C);
        wr(A_SAMP, 32'hFFFF_FFFF);
        rd(A_SAMP, v);
        chk("R3 sample ignores write", v, 32'hA5C);
        pin_in = 12'h000;
        cyc(3);
        wr(A_STAT, 32'hFFF);
        rd(A_STAT, v);
        chk("R6 status cleared after sample test", v, 32'h0);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        wr(A_PLO, 32'hFFFF_FFFF);
        rd(A_PLO, v);
        chk("R4 low polarity layout", v, 32'h1111_1111);
        wr(A_PHI, 32'hFFFF_FFFF);
        rd(A_PHI, v);
        chk("R4 high polarity layout", v, 32'h0000_1111);
        cyc(1);
        rd(A_STAT, v);
        chk("R4 all lines active-low latch", v, 32'hFFF);
        wr(A_PLO, 32'h0);
        wr(A_PHI, 32'h0000_0010);
        wr(A_STAT, 32'hFFF);
        cyc(1);
        rd(A_STAT, v);
        chk("R4 only line 9 active-low", v, 32'h200);
        @(negedge clk);
        pin_in = 12'h200;
        cyc(3);
        wr(A_STAT, 32'hFFF);
        cyc(1);
        rd(A_STAT, v);
        chk("R4 line 9 quiet when high", v, 32'h0);
        wr(A_PHI, 32'h0);
        pin_in = 12'h000;
        cyc(3);
        wr(A_STAT, 32'hFFF);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 12'h088;
        cyc(3);
        pin_in = 12'h000;
        cyc(4);
        rd(A_STAT, v);
        chk("R5 status held after pulse", v, 32'h088);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, v);
        chk("R6 clear one, keep zero-written", v, 32'h008);
        @(negedge clk);
        pin_in = 12'h020;
        cyc(4);
        rd(A_STAT, v);
        chk("R5 held line sets", v, 32'h028);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h020;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_STAT, v);
        chk("R7 cleared bit reads zero for one cycle", v, 32'h008);
        cyc(1);
        rd(A_STAT, v);
        chk("R7 cleared bit sets again", v, 32'h028);
        pin_in = 12'h000;
        cyc(3);
        wr(A_STAT, 32'hFFF);
        rd(A_STAT, v);
        chk("R6 all cleared", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 12'h002;
        cyc(3);
        pin_in = 12'h000;
        cyc(3);
        chk("R8 masked line no irq", {31'h0, host_irq}, 32'h0);
        wr(A_IEN, 32'h002);
        chk("R8 enabled line irq", {31'h0, host_irq}, 32'h1);
        wr(A_IEN, 32'h0);
        chk("R8 mask drops irq", {31'h0, host_irq}, 32'h0);
        rd(A_STAT, v);
        chk("R8 mask keeps status", v, 32'h002);
        wr(A_IEN, 32'h004);
        chk("R8 other line enabled only", {31'h0, host_irq}, 32'h0);
        wr(A_IEN, 32'h006);
        chk("R8 re-enable raises irq", {31'h0, host_irq}, 32'h1);
        rd(A_IEN, v);
        chk("R8 enable readback", v, 32'h006);
        wr(A_STAT, 32'h002);
        chk("R8 clear drops irq", {31'h0, host_irq}, 32'h0);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(A_ROUTE, 32'hDEAD_BEEF);
        rd(A_ROUTE, v);
        chk("R9 route readback", v, 32'hDEAD_BEEF);
        chk("R9 mux_sel", mux_sel, 32'hDEAD_BEEF);
        wr(A_ROUTE, 32'h1234_5678);
        chk("R9 mux_sel rewrite", mux_sel, 32'h1234_5678);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h02, 32'hFFFF_FFFF);
        wr(6'h1D, 32'hFFFF_FFFF);
        rd(6'h20, v);
        chk("R10 offset 0x20 reads zero", v, 32'h0);
        rd(6'h02, v);
        chk("R10 unaligned reads zero", v, 32'h0);
        chk("R10 pin_out untouched", {20'h0, pin_out}, 32'h5A5);
        chk("R10 pin_oe untouched", {20'h0, pin_oe}, 32'h0F0);
        chk("R10 mux_sel untouched", mux_sel, 32'h1234_5678);
        rd(A_IEN, v);
        chk("R10 enable untouched", v, 32'h0);
        wr(A_OE, 32'hFFFF_FFFF);
        rd(A_OE, v);
        chk("R10 oe upper bits zero", v, 32'hFFF);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_drive();
        t_sample();
        t_polarity();
        t_latch();
        t_mask();
        t_route();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule